// File: doc/BRIEF.md
# SD Data FIFO Byte Packer

This block sits between a host register port and the byte-wide data path of an SD card interface. It owns a circular buffer of sixteen 32-bit words. When the transfer direction is read, it gathers bytes arriving from the card and assembles them into words, least-significant byte first, then places each word in the buffer for the host to collect. When the direction is write, it takes words the host has placed in the buffer and hands them to the card one byte at a time, again least-significant byte first.

A transfer starts when the host writes the block-count register. The number of bytes still to move is the block count times the block size. The engine moves at most one byte per clock. It stops when the counter reaches zero. At that point it sets the state field of the debug register to data mode and, for writes, can raise a block-complete flag. Both card streams use valid/ready. A byte passes only in a cycle where valid and ready are both high. A stalled sender must hold its byte. The receive side also waits on a separate card data-ready level.

Top module: `sd_fifo_packer`

## Requirements
- R1: After reset the debug register (address 3) reads 0x0000C60F, the status register (address 2) reads 0 and the buffer is empty.
- R2: The buffer holds 16 words. A push while it is full is discarded and leaves the stored words unchanged. A pop while it is empty returns 0 and changes nothing.
- R3: A write to the block-count register (address 5) loads the remaining-byte counter with the written count times the block-size register (address 4), and processing then starts.
- R4: Read mode is mode register (address 0) bit 0 = 1. In read mode `card_rx_ready` is high only while bytes remain, `card_dready` is high and the buffer is not full. Accepted bytes fill a word from bit 0 upward, and every fourth byte pushes that word.
- R5: If the count ends partway through a word, the partial word is pushed with its missing upper bytes zero.
- R6: Every word the engine pushes or pops sets status bit 0 (data flag). Every full word pushed on a read, and every word popped on a write, also sets status bit 8 when config (address 1) bit 4 is set. A partial word never sets bit 8.
- R7: Write mode is mode bit 0 = 0. In write mode the engine pops a word and offers its bytes on `card_tx_data`, least-significant first. Each byte is held until `card_tx_ready` accepts it, and the counter drops by one per accepted byte.
- R8: When the counter reaches zero, debug bits 3:0 become 1. In write mode with config bit 8 set, status bit 9 is also set.
- R9: Debug bits 8:4 always read the buffer fill level. Writes to those bits have no effect.
- R10: A debug write whose bits 3:0 are 0xF stores 0 in those bits. Other debug writes store bits 3:0 and 31:9 as written.
- R11: Writing the status register clears each bit written as 1 (bits 0, 8, 9). `irq` is high when status bit 8 or bit 9 is set.
- R12: Reading the data register (address 6) returns the oldest word and pops it. Writing it pushes the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops when addressing data) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| irq | output | 1 | Interrupt, status bit 8 or 9 set |
| card_dready | input | 1 | Card has read data available |
| card_rx_valid | input | 1 | Read byte from card valid |
| card_rx_data | input | 8 | Read byte from card |
| card_rx_ready | output | 1 | Engine accepts a read byte |
| card_tx_valid | output | 1 | Write byte to card valid |
| card_tx_data | output | 8 | Write byte to card |
| card_tx_ready | input | 1 | Card accepts a write byte |

## Verification
The assertions assume the host does not change the mode or reload the block count while a write byte is waiting on the card. They also assume the host issues at most one register access per cycle. The stimulus keeps to this: it changes mode and configuration only once a transfer has finished, and it drives only one strobe at a time. Both card handshakes are throttled by fixed repeating patterns. This means bytes stall and resume at varied word offsets. The sweeps cover every block size from 1 to 7 with block counts from 1 to 3, and write lengths from 1 to 12. Each transfer is started only after the previous one has completed.

// File: rtl/sd_fifo_packer_pkg.sv
package sd_fifo_packer_pkg;
  localparam logic [2:0] RA_MODE   = 3'd0;
  localparam logic [2:0] RA_CFG    = 3'd1;
  localparam logic [2:0] RA_STAT   = 3'd2;
  localparam logic [2:0] RA_DBG    = 3'd3;
  localparam logic [2:0] RA_BSIZE  = 3'd4;
  localparam logic [2:0] RA_BCOUNT = 3'd5;
  localparam logic [2:0] RA_DATA   = 3'd6;

  localparam int unsigned CF_DATA_IE  = 4;
  localparam int unsigned CF_BLOCK_IE = 8;

  localparam logic [31:0] DBG_RESET    = 32'h0000_C60F;
  localparam logic [3:0]  FSM_DATAMODE = 4'h1;
endpackage

// File: rtl/sd_fifo_packer_fifo.sv
module sd_fifo_packer_fifo #(
  parameter int unsigned DEPTH = 16,  // power of two
  parameter int unsigned W     = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] fill,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_pos;
  logic [PTR_W:0]   wsum;
  logic             do_push, do_pop;

  assign full    = (fill == CNT_W'(DEPTH));
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign wsum    = {1'b0, rd_pos} + fill;
  assign head    = empty ? '0 : mem[rd_pos];

  always_ff @(posedge clk) begin
    if (do_push) mem[wsum[PTR_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pos <= '0;
      fill   <= '0;
    end else begin
      if (do_pop) rd_pos <= rd_pos + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + CNT_W'(1);
        2'b01:   fill <= fill - CNT_W'(1);
        default: fill <= fill;
      endcase
    end
  end

  // R2: level never exceeds the capacity
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));
  // R2: push into a full buffer is dropped
  a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (fill == CNT_W'(DEPTH)));
  // R2: pop from an empty buffer changes nothing
  a_r2_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (fill == '0));
endmodule

// File: rtl/sd_fifo_packer_engine.sv
module sd_fifo_packer_engine #(
  parameter int unsigned CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dir_read,
  input  logic             card_dready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic [31:0]      fifo_head,
  input  logic             host_push,
  input  logic             host_pop,
  output logic             eng_push,
  output logic [31:0]      eng_push_data,
  output logic             eng_pop,
  output logic             rx_full_word,
  output logic             done
);
  logic [CNT_W-1:0] remain;
  logic [1:0]       rx_n;
  logic [31:0]      rx_acc;
  logic [31:0]      tx_word;
  logic [2:0]       tx_left;
  logic             active, last, rx_take, tx_take, byte_done;

  assign active   = (remain != '0);
  assign last     = (remain == CNT_W'(1));
  assign rx_ready = active && dir_read && card_dready && !fifo_full && !host_push && !load;
  assign rx_take  = rx_ready && rx_valid;
  assign tx_valid = active && !dir_read && (tx_left != 3'd0);
  assign tx_data  = tx_word[7:0];
  assign tx_take  = tx_valid && tx_ready;
  assign eng_pop  = active && !dir_read && (tx_left == 3'd0) && !fifo_empty && !host_pop && !load;

  assign eng_push_data = rx_acc | (32'(rx_data) << {rx_n, 3'b000});
  assign eng_push      = rx_take && ((rx_n == 2'd3) || last);
  assign rx_full_word  = rx_take && (rx_n == 2'd3);
  assign byte_done     = rx_take || tx_take;
  assign done          = byte_done && last && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain  <= '0;
      rx_n    <= '0;
      rx_acc  <= '0;
      tx_word <= '0;
      tx_left <= '0;
    end else if (load) begin
      remain  <= load_val;
      rx_n    <= '0;
      rx_acc  <= '0;
      tx_left <= '0;
    end else begin
      if (byte_done) remain <= remain - CNT_W'(1);
      if (rx_take) begin
        if (eng_push) begin
          rx_n   <= '0;
          rx_acc <= '0;
        end else begin
          rx_n   <= rx_n + 2'd1;
          rx_acc <= eng_push_data;
        end
      end
      if (eng_pop) begin
        tx_word <= fifo_head;
        tx_left <= 3'd4;
      end else if (tx_take) begin
        tx_word <= tx_word >> 8;
        tx_left <= tx_left - 3'd1;
      end
    end
  end

  // R3: a load sets the remaining count to the product
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (remain == $past(load_val)));
  // R4 / R7: each accepted byte decrements the count by one
  a_r4_count: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !load) |=> (remain == $past(remain) - CNT_W'(1)));
  // R4: no read byte accepted while the buffer is full
  a_r4_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !rx_take);
endmodule

// File: rtl/sd_fifo_packer.sv
module sd_fifo_packer
  import sd_fifo_packer_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned BSIZE_W = 16,
  parameter int unsigned BCNT_W  = 9,
  localparam int unsigned CNT_W  = BSIZE_W + BCNT_W,
  localparam int unsigned FILL_W = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  input  logic        card_dready,
  input  logic        card_rx_valid,
  input  logic [7:0]  card_rx_data,
  output logic        card_rx_ready,
  output logic        card_tx_valid,
  output logic [7:0]  card_tx_data,
  input  logic        card_tx_ready
);
  logic               dir_read;
  logic [31:0]        cfg_q, dbg_q;
  logic [BSIZE_W-1:0] bsize_q;
  logic [BCNT_W-1:0]  bcnt_q;
  logic               st_data, st_sdio, st_block;

  logic               host_push, host_pop, load;
  logic [CNT_W-1:0]   load_val;
  logic               eng_push, eng_pop, rx_full_word, eng_done;
  logic [31:0]        eng_push_data, fifo_head;
  logic [FILL_W-1:0]  fifo_fill;
  logic               fifo_full, fifo_empty;

  assign host_push = reg_wr && (reg_addr == RA_DATA);
  assign host_pop  = reg_rd && (reg_addr == RA_DATA);
  assign load      = reg_wr && (reg_addr == RA_BCOUNT);
  assign load_val  = CNT_W'(reg_wdata[BCNT_W-1:0]) * CNT_W'(bsize_q);

  sd_fifo_packer_fifo #(.DEPTH(DEPTH), .W(32)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (host_push || eng_push),
    .push_data (eng_push ? eng_push_data : reg_wdata),
    .pop       (host_pop || eng_pop),
    .head      (fifo_head),
    .fill      (fifo_fill),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  sd_fifo_packer_engine #(.CNT_W(CNT_W)) eng_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (load),
    .load_val      (load_val),
    .dir_read      (dir_read),
    .card_dready   (card_dready),
    .rx_valid      (card_rx_valid),
    .rx_data       (card_rx_data),
    .rx_ready      (card_rx_ready),
    .tx_valid      (card_tx_valid),
    .tx_data       (card_tx_data),
    .tx_ready      (card_tx_ready),
    .fifo_full     (fifo_full),
    .fifo_empty    (fifo_empty),
    .fifo_head     (fifo_head),
    .host_push     (host_push),
    .host_pop      (host_pop),
    .eng_push      (eng_push),
    .eng_push_data (eng_push_data),
    .eng_pop       (eng_pop),
    .rx_full_word  (rx_full_word),
    .done          (eng_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_read <= 1'b0;
      cfg_q    <= '0;
      dbg_q    <= DBG_RESET;
      bsize_q  <= '0;
      bcnt_q   <= '0;
      st_data  <= 1'b0;
      st_sdio  <= 1'b0;
      st_block <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_MODE:   dir_read <= reg_wdata[0];
          RA_CFG:    cfg_q    <= reg_wdata;
          RA_BSIZE:  bsize_q  <= reg_wdata[BSIZE_W-1:0];
          RA_BCOUNT: bcnt_q   <= reg_wdata[BCNT_W-1:0];
          RA_DBG:    dbg_q    <= {reg_wdata[31:4],
                                  (reg_wdata[3:0] == 4'hF) ? 4'h0 : reg_wdata[3:0]};
          default:   ;
        endcase
      end
      if (eng_done) dbg_q[3:0] <= FSM_DATAMODE;

      st_data  <= (st_data  && !(reg_wr && reg_addr == RA_STAT && reg_wdata[0]))
                  || eng_push || eng_pop;
      st_sdio  <= (st_sdio  && !(reg_wr && reg_addr == RA_STAT && reg_wdata[8]))
                  || ((rx_full_word || eng_pop) && cfg_q[CF_DATA_IE]);
      st_block <= (st_block && !(reg_wr && reg_addr == RA_STAT && reg_wdata[9]))
                  || (eng_done && !dir_read && cfg_q[CF_BLOCK_IE]);
    end
  end

  assign irq = st_sdio || st_block;

  always_comb begin
    case (reg_addr)
      RA_MODE:   reg_rdata = {31'b0, dir_read};
      RA_CFG:    reg_rdata = cfg_q;
      RA_STAT:   reg_rdata = {22'b0, st_block, st_sdio, 7'b0, st_data};
      RA_DBG:    reg_rdata = {dbg_q[31:9], 5'(fifo_fill), dbg_q[3:0]};
      RA_BSIZE:  reg_rdata = 32'(bsize_q);
      RA_BCOUNT: reg_rdata = 32'(bcnt_q);
      RA_DATA:   reg_rdata = fifo_head;
      default:   reg_rdata = '0;
    endcase
  end

  // R8: completion returns the state field to data mode
  a_r8_state: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (dbg_q[3:0] == FSM_DATAMODE));
  // R6: a write-side pop with data interrupts enabled raises bit 8
  a_r6_sdio: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_pop && cfg_q[CF_DATA_IE]) |=> st_sdio);
  // R7: an offered write byte is held until accepted
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (card_tx_valid && !card_tx_ready && !(reg_wr && (reg_addr == RA_MODE || reg_addr == RA_BCOUNT)))
    |=> (card_tx_valid && card_tx_data == $past(card_tx_data)));
  // R11: irq follows the interrupt status bits
  a_r11_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq)) |-> (st_sdio || st_block));
endmodule

// File: tb/sd_fifo_packer_tb_top.sv
`timescale 1ns/1ps
module sd_fifo_packer_tb_top;
  localparam logic [2:0] A_MODE = 3'd0, A_CFG = 3'd1, A_STAT = 3'd2, A_DBG = 3'd3,
                         A_BSIZE = 3'd4, A_BCOUNT = 3'd5, A_DATA = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        card_dready = 1'b1;
  logic        card_rx_valid = 1'b0;
  logic [7:0]  card_rx_data;
  logic        card_rx_ready;
  logic        card_tx_valid;
  logic [7:0]  card_tx_data;
  logic        card_tx_ready = 1'b0;

  int unsigned n_chk = 0, n_err = 0;
  bit          finished = 1'b0;

  logic [7:0]  rx_base = '0;
  logic [7:0]  rx_idx;
  logic        rx_clr = 1'b0;
  logic [7:0]  tx_log [128];
  int unsigned tx_n;
  logic        tx_clr = 1'b0;
  logic [31:0] exp_w [32];

  always #2 clk = ~clk;

  sd_fifo_packer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .card_dready(card_dready),
    .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data), .card_rx_ready(card_rx_ready),
    .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready)
  );

  assign card_rx_data = rx_base + rx_idx;

  always @(posedge clk) begin
    if (rx_clr) rx_idx <= '0;
    else if (card_rx_valid && card_rx_ready) rx_idx <= rx_idx + 8'd1;
  end

  always @(posedge clk) begin
    if (tx_clr) tx_n <= 0;
    else if (card_tx_valid && card_tx_ready) begin
      tx_log[tx_n[6:0]] <= card_tx_data;
      tx_n <= tx_n + 1;
    end
  end

  initial begin
    int unsigned tick = 0;
    forever begin
      @(negedge clk);
      tick++;
      card_tx_ready = (tick % 3) != 1;
      card_rx_valid = (tick % 4) != 2;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = (a == A_DATA);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); rx_clr = 1'b1; tx_clr = 1'b1;
    @(negedge clk); rx_clr = 1'b0; tx_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e;
    rx_clr = 1'b1; tx_clr = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rx_clr = 1'b0; tx_clr = 1'b0;

    // R1 reset state
    rd(A_DBG, v);  chk("R1 debug reset", v, 32'h0000_C60F);
    rd(A_STAT, v); chk("R1 status reset", v, 32'h0);
    chk("R11 irq after reset", {31'b0, irq}, 32'h0);
    rd(A_DATA, v); chk("R2 pop of empty returns zero", v, 32'h0);

    // R10 debug nibble handling, R9 fill field read-only
    wr(A_DBG, 32'hABCD_123F);
    rd(A_DBG, v);  chk("R10 nibble F cleared, R9 fill bits", v, 32'hABCD_1200);
    wr(A_DBG, 32'h0000_0005);
    rd(A_DBG, v);  chk("R10 nibble stored", v, 32'h0000_0005);

    // R2 / R12 overflow: 17 pushes, idle engine
    wr(A_MODE, 32'h1);
    for (int i = 0; i < 17; i++) wr(A_DATA, 32'h1000 + i);
    rd(A_DBG, v);  chk("R9 fill at full", (v >> 4) & 32'h1F, 32'd16);
    for (int i = 0; i < 16; i++) begin
      rd(A_DATA, v); chk("R12 pop order", v, 32'h1000 + i);
    end
    rd(A_DATA, v); chk("R2 dropped push absent", v, 32'h0);

    // R3 R4 R5 R6 R8 read sweep
    for (int bc = 1; bc <= 3; bc++) begin
      for (int bs = 1; bs <= 7; bs++) begin
        int n, nw;
        logic [31:0] cfg;
        n = bs * bc; nw = (n + 3) / 4;
        cfg = ((bs % 2) == 1) ? 32'h110 : 32'h0;
        wr(A_MODE, 32'h1); wr(A_CFG, cfg);
        wr(A_STAT, 32'hFFFF_FFFF); wr(A_DBG, 32'h0);
        rx_base = 8'(n * 17);
        pulse_clr();
        wr(A_BSIZE, bs); wr(A_BCOUNT, bc);
        idle(80);
        rd(A_DBG, v);
        chk("R8 read completion state", v & 32'hF, 32'h1);
        chk("R9 fill after read", (v >> 4) & 32'h1F, nw);
        rd(A_STAT, v);
        e = 32'h1 | ((cfg[4] && n >= 4) ? 32'h100 : 32'h0);
        chk("R6 read status flags", v, e);
        for (int k = 0; k < nw; k++) begin
          e = '0;
          for (int j = 0; j < 4; j++)
            if (4 * k + j < n) e[8*j +: 8] = 8'(n * 17 + 4 * k + j);
          rd(A_DATA, v);
          chk((4 * k + 4 > n) ? "R5 partial word" : "R4 packed word", v, e);
        end
      end
    end

    // R4 long read stalls at full buffer
    wr(A_MODE, 32'h1); wr(A_CFG, 32'h0); wr(A_STAT, 32'hFFFF_FFFF); wr(A_DBG, 32'h0);
    rx_base = 8'h40; pulse_clr();
    wr(A_BSIZE, 4); wr(A_BCOUNT, 20);
    idle(200);
    rd(A_DBG, v);
    chk("R4 stall at full", (v >> 4) & 32'h1F, 32'd16);
    chk("R8 not complete while stalled", v & 32'hF, 32'h0);
    for (int k = 0; k < 20; k++) begin
      idle(20);
      e = '0;
      for (int j = 0; j < 4; j++) e[8*j +: 8] = 8'(8'h40 + 4 * k + j);
      rd(A_DATA, v); chk("R4 long read word", v, e);
    end
    rd(A_DBG, v); chk("R8 long read done", v & 32'hF, 32'h1);

    // R4 data-ready low holds the read
    wr(A_DBG, 32'h0); card_dready = 1'b0;
    rx_base = 8'h90; pulse_clr();
    wr(A_BSIZE, 4); wr(A_BCOUNT, 1);
    idle(30);
    rd(A_DBG, v); chk("R4 no bytes without dready", v & 32'h1FF, 32'h0);
    card_dready = 1'b1;
    idle(30);
    rd(A_DATA, v); chk("R4 word after dready", v, 32'h9392_9190);

    // R7 R8 R6 write sweep
    for (int m = 1; m <= 12; m++) begin
      int nw, extra;
      logic [31:0] cfg;
      nw = (m + 3) / 4; extra = m % 2;
      cfg = ((m % 2) == 0) ? 32'h110 : 32'h0;
      wr(A_MODE, 32'h0); wr(A_CFG, cfg);
      wr(A_STAT, 32'hFFFF_FFFF); wr(A_DBG, 32'h0);
      pulse_clr();
      for (int k = 0; k < nw + extra; k++) begin
        exp_w[k] = 32'h0102_0304 * m + 32'h1111_1111 * k + 32'h8000_0000;
        wr(A_DATA, exp_w[k]);
      end
      wr(A_BSIZE, m); wr(A_BCOUNT, 1);
      idle(80);
      chk("R7 byte count sent", tx_n, m);
      for (int b = 0; b < m; b++)
        chk("R7 byte order", {24'b0, tx_log[b]}, {24'b0, exp_w[b / 4][8 * (b % 4) +: 8]});
      rd(A_DBG, v);
      chk("R8 write completion state", v & 32'hF, 32'h1);
      chk("R9 leftover fill", (v >> 4) & 32'h1F, extra);
      rd(A_STAT, v);
      e = 32'h1 | (cfg[4] ? 32'h100 : 32'h0) | (cfg[8] ? 32'h200 : 32'h0);
      chk("R8 R6 write status flags", v, e);
      chk("R11 irq level", {31'b0, irq}, {31'b0, cfg[4]});
      for (int k = 0; k < extra; k++) begin
        rd(A_DATA, v); chk("R2 leftover word", v, exp_w[nw + k]);
      end
    end

    // R11 write-one-to-clear, bits independent
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R11 clear bit 0 only", v, 32'h300);
    wr(A_STAT, 32'h100);
    rd(A_STAT, v); chk("R11 clear bit 8", v, 32'h200);
    chk("R11 irq from block bit", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h200);
    rd(A_STAT, v); chk("R11 all clear", v, 32'h0);
    chk("R11 irq low", {31'b0, irq}, 32'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule